// File: doc/BRIEF.md
# Daisy-Chained ADC Readout Sequencer

This block runs the host side of a chain of identical successive-approximation converters that share one convert strobe and one serial clock, with each converter's serial output wired to the next one's serial input. Only the last converter's output comes back to the host. On request, the sequencer raises the convert strobe and holds it for the worst-case conversion time. It then issues one unbroken burst of serial clocks, one for every bit of every converter in the chain. It samples the returning stream and splits it into one result word per converter.

A level-sensitive start request triggers a single conversion, and a free-run input repeats conversions back to back at the configured cycle period. Every timing count is a parameter in system clocks. The sequencer never starts a conversion sooner than one full cycle period after the previous one. It raises a configuration error, and stays idle, when the serial clock would be too fast or when the burst cannot fit in the cycle.

Top module: `adc_chain_reader`

## Requirements
- R1: After reset, `cnv`, `sck`, `busy` and `res_valid` are all low.
- R2: A conversion begins on the first clock where `start` or `free_run` is high, the block is idle, the cycle period has elapsed and `cfg_err` is low. `cnv` then stays high for exactly CONV_CLKS clocks, and `sck` stays low throughout that time.
- R3: After `cnv` falls, `sck` makes exactly RES×NUM_DEV rising edges. Each high phase and each low phase lasts SCK_HALF clocks. `sck` idles low between bursts.
- R4: `sdi` is sampled at each rising `sck` edge, most significant bit first. The first RES bits form word 0, at `res_data[RES-1:0]`. Word k occupies `res_data[k*RES +: RES]`, and higher k lies farther up the chain.
- R5: `res_valid` pulses for one clock, beginning at the clock after the final falling `sck` edge. `busy` is high from the clock on which `cnv` rises until that pulse and is low during the pulse.
- R6: Rising edges of `cnv` are never closer than CYCLE_CLKS clocks apart. With `free_run` held high, they are exactly CYCLE_CLKS apart.
- R7: `cfg_err` is high when SCK_HALF < MIN_SCK_HALF, or when CONV_CLKS + 2×SCK_HALF×RES×NUM_DEV + 1 > CYCLE_CLKS. While `cfg_err` is high, `cnv` never rises.
- R8: `start` has no effect while `busy` is high. `res_data` keeps the last delivered words until the next `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Level request for a single conversion |
| free_run | input | 1 | Repeat conversions at the cycle period |
| sdi | input | 1 | Serial data from the last converter in the chain |
| cnv | output | 1 | Convert strobe to all converters |
| sck | output | 1 | Serial clock to all converters |
| busy | output | 1 | Conversion or readout in progress |
| res_valid | output | 1 | One-clock pulse: new result words |
| res_data | output | RES×NUM_DEV | Result words, word k at bits [k*RES +: RES] |
| cfg_err | output | 1 | Timing parameters are not usable |

## Verification
The hardest case to reach is a request that arrives before the cycle period has run out. The sequencer must hold the request rather than drop it or start early. The bench raises `start` in the clock right after `res_valid` and holds it there, then measures the spacing between `cnv` rising edges against CYCLE_CLKS. A separate burst has `start` toggled during the readout to show that it is ignored, and the held result words are compared while the next readout is in progress.

// File: rtl/adc_chain_pkg.sv
// Shared types for the daisy-chained ADC readout sequencer.
package adc_chain_pkg;
    // Sequencer phases: waiting, converting, shifting the chain out.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CONV  = 2'd1,
        PH_SHIFT = 2'd2
    } phase_t;
endpackage

// File: rtl/adc_chain_pacer.sv
// Cycle pacer: counts clocks since the last convert start and reports when
// a new conversion is permitted. Assumes CYCLE_CLKS >= 2. Starts "ready".
module adc_chain_pacer #(
    parameter int CYCLE_CLKS = 240
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic cycle_ok
);
    localparam int CW = $clog2(CYCLE_CLKS + 1);

    logic [CW-1:0] since_q;

    // Count clocks since launch, saturating at the cycle length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_q <= CW'(CYCLE_CLKS);
        else if (launch)
            since_q <= CW'(1);
        else if (since_q != CW'(CYCLE_CLKS))
            since_q <= since_q + CW'(1);
    end

    assign cycle_ok = (since_q == CW'(CYCLE_CLKS));
endmodule

// File: rtl/adc_chain_sck_gen.sv
// Serial clock generator: while run is high, toggles sck every SCK_HALF
// clocks, starting from low. Flags the edge on which sck will rise or fall.
// Assumes SCK_HALF >= 1.
module adc_chain_sck_gen #(
    parameter int SCK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise_now,
    output logic fall_now
);
    localparam int HW = $clog2(SCK_HALF + 1);

    logic [HW-1:0] half_q;
    logic          tick;

    assign tick     = run && (half_q == HW'(SCK_HALF - 1));
    assign rise_now = tick && !sck;
    assign fall_now = tick && sck;

    // Half-period counter and clock toggle; idles low when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            half_q <= '0;
            sck    <= 1'b0;
        end else if (tick) begin
            half_q <= '0;
            sck    <= ~sck;
        end else begin
            half_q <= half_q + HW'(1);
        end
    end

    // R3
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sck);
endmodule

// File: rtl/adc_chain_deser.sv
// Deserializer: shifts sdi in MSB first on each shift strobe, and on load
// copies the whole stream into the output. The first RES bits that arrived
// become word 0. Assumes exactly WORDS*RES shifts precede each load.
module adc_chain_deser #(
    parameter int RES   = 18,
    parameter int WORDS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift,
    input  logic                 sdi,
    input  logic                 load,
    output logic [WORDS*RES-1:0] words
);
    localparam int W = WORDS * RES;

    logic [W-1:0] sr_q;
    logic [W-1:0] out_q;

    // Collect the serial stream.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (shift)
            sr_q <= {sr_q[W-2:0], sdi};
    end

    // Latch the finished stream for the consumer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else if (load)
            out_q <= sr_q;
    end

    // Reorder: earliest RES bits map to word 0.
    for (genvar k = 0; k < WORDS; k++) begin : g_word
        assign words[k*RES +: RES] = out_q[W-1-k*RES -: RES];
    end
endmodule

// File: rtl/adc_chain_reader.sv
// Daisy-chained ADC readout sequencer (top). Drives one convert strobe and
// one serial clock shared by NUM_DEV converters, reads RES*NUM_DEV bits from
// the chain end and presents NUM_DEV words. All timing is in system clocks.
// Assumes sdi is already synchronous to clk.
module adc_chain_reader
    import adc_chain_pkg::*;
#(
    parameter int NUM_DEV      = 3,
    parameter int RES          = 18,
    parameter int CONV_CLKS    = 5,
    parameter int SCK_HALF     = 2,
    parameter int MIN_SCK_HALF = 2,
    parameter int CYCLE_CLKS   = 240
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   free_run,
    input  logic                   sdi,
    output logic                   cnv,
    output logic                   sck,
    output logic                   busy,
    output logic                   res_valid,
    output logic [NUM_DEV*RES-1:0] res_data,
    output logic                   cfg_err
);
    localparam int W       = NUM_DEV * RES;
    localparam int BW      = $clog2(W + 1);
    localparam int KW      = $clog2(CONV_CLKS + 1);
    localparam int NEED    = CONV_CLKS + 2 * SCK_HALF * W + 1;
    localparam bit BAD_CFG = (SCK_HALF < MIN_SCK_HALF) || (NEED > CYCLE_CLKS);

    phase_t        ph_q;
    logic [KW-1:0] conv_q;
    logic [BW-1:0] bits_q;
    logic          valid_q;
    logic          cycle_ok, go, rise_now, fall_now, done;

    assign cfg_err = BAD_CFG;
    assign go      = (ph_q == PH_IDLE) && (start || free_run) && cycle_ok && !BAD_CFG;
    assign done    = (ph_q == PH_SHIFT) && fall_now && (bits_q == BW'(W));

    adc_chain_pacer #(.CYCLE_CLKS(CYCLE_CLKS)) u_pacer (
        .clk(clk), .rst_n(rst_n), .launch(go), .cycle_ok(cycle_ok)
    );

    adc_chain_sck_gen #(.SCK_HALF(SCK_HALF)) u_sck (
        .clk(clk), .rst_n(rst_n), .run(ph_q == PH_SHIFT),
        .sck(sck), .rise_now(rise_now), .fall_now(fall_now)
    );

    adc_chain_deser #(.RES(RES), .WORDS(NUM_DEV)) u_deser (
        .clk(clk), .rst_n(rst_n), .shift(rise_now), .sdi(sdi),
        .load(done), .words(res_data)
    );

    // Phase sequencing: convert, wait out conversion, shift the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            conv_q <= '0;
            bits_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: if (go) begin
                    ph_q   <= PH_CONV;
                    conv_q <= '0;
                end
                PH_CONV: if (conv_q == KW'(CONV_CLKS - 1)) begin
                    ph_q   <= PH_SHIFT;
                    bits_q <= '0;
                end else begin
                    conv_q <= conv_q + KW'(1);
                end
                PH_SHIFT: begin
                    if (rise_now) bits_q <= bits_q + BW'(1);
                    if (done)     ph_q   <= PH_IDLE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // One-clock result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= done;
    end

    assign cnv       = (ph_q == PH_CONV);
    assign busy      = (ph_q != PH_IDLE);
    assign res_valid = valid_q;

    // Checker-side counters, independent of the sequencing counters.
    localparam int CW = $clog2(CYCLE_CLKS + 1);
    logic [CW-1:0] gap_q;
    logic [BW:0]   rises_q;
    logic          sck_d;

    // Track clocks since the last cnv rise and sck rises in the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q   <= CW'(CYCLE_CLKS);
            rises_q <= '0;
            sck_d   <= 1'b0;
        end else begin
            sck_d <= sck;
            if (cnv && !busy_d) gap_q <= CW'(1);
            else if (gap_q != CW'(CYCLE_CLKS)) gap_q <= gap_q + CW'(1);
            if (cnv) rises_q <= '0;
            else if (sck && !sck_d) rises_q <= rises_q + 1'b1;
        end
    end

    logic busy_d;
    // Previous busy, to find the first convert clock.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_d <= 1'b0;
        else        busy_d <= busy;
    end

    // R2
    sck_quiet_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv |-> !sck);
    // R3
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (rises_q == (BW+1)'(W)));
    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (!busy && $past(busy)));
    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R6
    cycle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv && !busy_d) |-> (gap_q == CW'(CYCLE_CLKS)));
    // R7
    cfg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !busy);
endmodule

// File: tb/adc_chain_reader_test.sv
module adc_chain_reader_test;
    localparam int N     = 3;
    localparam int RES   = 18;
    localparam int W     = N * RES;
    localparam int CONV  = 5;
    localparam int HALF  = 2;
    localparam int CYC   = 240;

    logic clk = 0, rst_n = 0, start = 0, free_run = 0, sdi = 0;
    logic cnv, sck, busy, res_valid, cfg_err;
    logic [W-1:0] res_data;
    logic b_cnv, b_sck, b_busy, b_valid, b_err;
    logic [W-1:0] b_data;

    always #4 clk = ~clk;

    adc_chain_reader #(.NUM_DEV(N), .RES(RES), .CONV_CLKS(CONV), .SCK_HALF(HALF),
        .MIN_SCK_HALF(2), .CYCLE_CLKS(CYC)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .free_run(free_run), .sdi(sdi),
        .cnv(cnv), .sck(sck), .busy(busy), .res_valid(res_valid),
        .res_data(res_data), .cfg_err(cfg_err));

    // R7: serial clock faster than allowed.
    adc_chain_reader #(.NUM_DEV(N), .RES(RES), .CONV_CLKS(CONV), .SCK_HALF(1),
        .MIN_SCK_HALF(2), .CYCLE_CLKS(CYC)) uut_bad (
        .clk(clk), .rst_n(rst_n), .start(1'b1), .free_run(1'b0), .sdi(1'b0),
        .cnv(b_cnv), .sck(b_sck), .busy(b_busy), .res_valid(b_valid),
        .res_data(b_data), .cfg_err(b_err));

    int tests = 0, fails = 0;
    logic [W-1:0] stream_q[$];
    logic [W-1:0] exp_q[$];
    logic [W-1:0] cur, last_words;
    int idx = 0, cnv_len = 0, hi_len = 0, rises = 0, gap = 100000, cnv_rises = 0;
    int bad_cnv = 0;
    logic cnv_p = 0, sck_p = 0, busy_p = 0;

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: queue a conversion's input stream and expected words.
    task automatic push(input logic [RES-1:0] w0, input logic [RES-1:0] w1,
                        input logic [RES-1:0] w2);
        stream_q.push_back({w0, w1, w2});
        exp_q.push_back({w2, w1, w0});
    endtask

    task automatic single(input logic [RES-1:0] w0, input logic [RES-1:0] w1,
                          input logic [RES-1:0] w2);
        push(w0, w1, w2);
        @(negedge clk) start = 1;
        wait (busy);
        @(negedge clk) start = 0;
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    // Monitor / chain model, sampled on the falling clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (b_cnv) bad_cnv++;
            if (cnv && !cnv_p) begin
                cnv_rises++;
                // R6: spacing of convert edges
                chk(gap >= CYC, "R6 gap", W'(gap), W'(CYC));
                if (free_run && cnv_rises > 1 && gap < 1000)
                    chk(gap == CYC, "R6 free-run gap", W'(gap), W'(CYC));
                gap = 1;
                cur = (stream_q.size() > 0) ? stream_q.pop_front() : '0;
                idx = 0;
                sdi = cur[W-1];
                rises = 0;
                cnv_len = 0;
            end else gap++;
            if (cnv) begin
                cnv_len++;
                if (sck) chk(0, "R2 sck during cnv", W'(sck), '0);
            end
            if (!cnv && cnv_p) chk(cnv_len == CONV, "R2 cnv length", W'(cnv_len), W'(CONV));
            if (sck) hi_len++;
            if (!sck && sck_p) begin
                chk(hi_len == HALF, "R3 sck high phase", W'(hi_len), W'(HALF));
                hi_len = 0;
            end
            if (sck && !sck_p) begin
                rises++;
                idx++;
                sdi = (idx < W) ? cur[W-1-idx] : 1'b0;
            end
            if (res_valid) begin
                chk(rises == W, "R3 sck rises", W'(rises), W'(W));
                chk(!busy && busy_p, "R5 busy at valid", {busy, busy_p}, 2'b01);
                if (exp_q.size() > 0) begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    for (int k = 0; k < N; k++)
                        chk(res_data[k*RES +: RES] == e[k*RES +: RES],
                            $sformatf("R4 word %0d", k), res_data, e);
                    last_words = e;
                end else chk(0, "R5 unexpected valid", res_data, '0);
            end
            cnv_p = cnv; sck_p = sck; busy_p = busy;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", '0, '1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({cnv, sck, busy, res_valid} == 4'b0, "R1 reset", {cnv, sck, busy, res_valid}, '0);
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        chk({cnv, sck, busy, res_valid} == 4'b0, "R1 after reset", {cnv, sck, busy, res_valid}, '0);
        // R7: error flags
        chk(cfg_err == 0, "R7 good cfg", W'(cfg_err), '0);
        chk(b_err == 1, "R7 bad cfg", W'(b_err), W'(1));

        single(18'h3FFFF, 18'h00000, 18'h2AAAA);
        single(18'h00001, 18'h20000, 18'h15555);
        // Immediate re-request after valid: must wait for the cycle (R6).
        push(18'h12345, 18'h0ABCD, 18'h3C3C3);
        start = 1;
        wait (busy);
        @(negedge clk) start = 0;
        // R8: start toggled mid-burst, words held while shifting.
        wait (sck);
        repeat (20) @(negedge clk);
        start = 1;
        repeat (30) @(negedge clk);
        start = 0;
        chk(res_data == {18'h15555, 18'h20000, 18'h00001}, "R8 held words", res_data,
            {18'h15555, 18'h20000, 18'h00001});
        wait (exp_q.size() == 0);
        @(negedge clk);
        chk(!busy, "R8 start ignored while busy", W'(busy), '0);

        // R6: free-running, exact spacing.
        begin
            int base;
            base = cnv_rises;
            push(18'h11111, 18'h22222, 18'h33333);
            push(18'h3FFFE, 18'h00002, 18'h1F0F0);
            push(18'h0F0F0, 18'h30303, 18'h07070);
            free_run = 1;
            wait (cnv_rises == base + 3);
            @(negedge clk) free_run = 0;
            wait (exp_q.size() == 0);
            repeat (CYC) @(negedge clk);
            chk(cnv_rises == base + 3, "R6 stop free-run", W'(cnv_rises), W'(base + 3));
        end
        // R7: bad instance never converted.
        chk(bad_cnv == 0, "R7 no convert on bad cfg", W'(bad_cnv), '0);
        chk({sck, res_valid, busy} == 3'b0, "R3 idle low", {sck, res_valid, busy}, '0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule